// File: doc/BRIEF.md
# SAR ADC Scan Sequencer

This block is the digital half of a 10-bit successive-approximation converter with five multiplexed inputs. Once started, it walks an inclusive range of channels. For each channel it spends a sampling window with the trial code at zero, then resolves the result one bit at a time from the most significant bit down. On each step it drives a trial code to an external DAC and reads back an external comparator decision. The comparator, the DAC and the input multiplexer sit outside the block. So does the clock prescaler, which reaches the block only as a one-cycle conversion-clock enable.

A pass is started by one of three sources, chosen by a select field: a falling edge on an active-low pin, a timer compare pulse, or a software start pulse. Each finished conversion is written to that channel's own result buffer and to a shared data register. When enabled, a window check compares every result with an upper and a lower bound. A one-shot pass returns to idle. In continuous mode, passes repeat until the run control is cleared. Two sticky flags, pass complete and out of window, serve as the interrupt requests. Software clears each one by writing 1 to its clear input.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset: `busy`, `sampling`, `done_flag` and `oor_flag` are 0. `dac_code` and `data_out` are 0. Every channel buffer reads 0.
- R2: `trig_sel` picks the start source: 0 is a falling edge of `ext_trig_n` (after a two-flop synchroniser), 1 is a `tmr_match` pulse, 2 is a `sw_start` pulse, and 3 is no source. A trigger starts a pass only when the block is idle and `run_en` is 1. Pulses on sources that are not selected have no effect.
- R3: A trigger that arrives while a pass is in progress is ignored. The pass runs to its normal end, and no further pass follows it in one-shot mode.
- R4: Each channel takes 20 `conv_en` ticks: 8 sampling ticks with `sampling` high, 10 decision ticks, and 2 write-back ticks. The counters move only on ticks. With `conv_en` held at 1 and a one-channel range, `done_flag` is set on the 21st rising edge after the start pulse is presented.
- R5: During decision tick k (k = 0..9), `dac_code` is the bits resolved so far with bit 9-k added as a trial bit. At the end of the tick that bit is kept if `cmp_in` is 1 and cleared if it is 0. With an ideal comparator (`cmp_in` = input >= `dac_code`), the result equals the input code.
- R6: A pass converts the channels from `ch_start` up to `ch_end` in ascending order. Either value above 4 is treated as 4. If the start channel is above the end channel, only the start channel is converted.
- R7: Each written result goes to its channel's buffer, read through `buf_rd_ch`/`buf_rd_data`, and to `data_out`. Buffers of channels outside the range keep their contents.
- R8: In one-shot mode (`mode_cont`=0), `busy` falls on the same edge that writes the last channel of the range.
- R9: In continuous mode, a new pass starts from the start channel without a trigger for as long as `run_en` is 1. When `run_en` is cleared, the current pass completes and the block then stays idle.
- R10: `done_flag` is set on the edge that writes the last channel of a pass. It stays set until `done_clr` is 1. If the set and the clear fall in the same cycle, the set wins.
- R11: With `win_en`=1, a result strictly above `upper_lim` or strictly below `lower_lim` sets `oor_flag`. A result equal to either bound does not. The flag is sticky, is cleared by `oor_clr`, and a set wins over a clear in the same cycle.
- R12: With `win_en`=0, no result sets `oor_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_en | input | 1 | Conversion-clock tick from the prescaler |
| run_en | input | 1 | Enable; clearing it stops continuous mode |
| mode_cont | input | 1 | 1 selects continuous mode, 0 selects one-shot |
| trig_sel | input | 2 | Start source select |
| ext_trig_n | input | 1 | Asynchronous active-low external trigger |
| tmr_match | input | 1 | Timer compare pulse |
| sw_start | input | 1 | Software start pulse |
| ch_start | input | 3 | First channel of the range |
| ch_end | input | 3 | Last channel of the range |
| win_en | input | 1 | Window check enable |
| upper_lim | input | 10 | Upper window bound |
| lower_lim | input | 10 | Lower window bound |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| done_clr | input | 1 | Write-1 clear for `done_flag` |
| oor_clr | input | 1 | Write-1 clear for `oor_flag` |
| buf_rd_ch | input | 3 | Buffer read channel |
| dac_code | output | 10 | Trial code to the DAC |
| ch_sel | output | 3 | Multiplexer channel select |
| sampling | output | 1 | High during the sampling window |
| busy | output | 1 | A pass is in progress |
| data_out | output | 10 | Most recent result |
| buf_rd_data | output | 10 | Buffer contents of `buf_rd_ch` |
| done_flag | output | 1 | Pass-complete interrupt flag |
| oor_flag | output | 1 | Out-of-window interrupt flag |

## Verification
Two events can land in the same cycle: the write-back that sets `done_flag` and `oor_flag`, and a software write-1 clear of those same flags. The bench holds `conv_en` at 1 and starts a one-channel pass whose result lies below the lower bound, which makes the write-back edge exactly the 21st rising edge after the start pulse. It raises both clears so that they are present at that edge. Afterwards, both flags must read 1, and a later clear on its own must bring each flag back to 0.

// File: rtl/adc_scan_pkg.sv
// Package: shared sizes and trigger-source encoding for the ADC scan sequencer.
// Assumes: 10-bit SAR, five channels, 8 + 10 + 2 tick budget per channel.
package adc_scan_pkg;
    localparam int RES_W      = 10;
    localparam int NUM_CH     = 5;
    localparam int CH_W       = 3;
    localparam int SAMPLE_CYC = 8;
    localparam int WB_CYC     = 2;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_SW   = 2'd2,
        SRC_NONE = 2'd3
    } trig_src_e;
endpackage

// File: rtl/adc_scan_trig.sv
// Module: start-source selection. Synchronises the asynchronous active-low
// pin through SYNC_STAGES flops, detects its falling edge and multiplexes
// the three sources into one start pulse.
// Assumes: timer and software inputs are already one-cycle synchronous pulses.
module adc_scan_trig
    import adc_scan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_trig_n,
    input  logic       tmr_match,
    input  logic       sw_start,
    input  logic [1:0] trig_sel,
    output logic       fire
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_fall;

    // Synchroniser chain plus the one-flop history used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig_n};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A high-to-low transition of the synchronised pin.
    assign ext_fall = prev_q & ~sync_q[SYNC_STAGES-1];

    // Source multiplexer.
    always_comb begin
        unique case (trig_src_e'(trig_sel))
            SRC_EXT: fire = ext_fall;
            SRC_TMR: fire = tmr_match;
            SRC_SW:  fire = sw_start;
            default: fire = 1'b0;
        endcase
    end

    // R2: an edge-detect pulse lasts exactly one cycle.
    assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !ext_fall);
endmodule

// File: rtl/adc_scan_sar.sv
// Module: pass sequencer and successive-approximation engine. Counts
// conversion ticks per channel, presents trial codes, keeps or drops each
// trial bit from the comparator, and emits a write strobe per channel.
// Assumes: conv_en is a one-cycle tick; cmp_in is valid at each decision tick.
module adc_scan_sar
    import adc_scan_pkg::*;
#(
    parameter int RES_W_P      = RES_W,
    parameter int NUM_CH_P     = NUM_CH,
    parameter int CH_W_P       = CH_W,
    parameter int SAMPLE_CYC_P = SAMPLE_CYC,
    parameter int WB_CYC_P     = WB_CYC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_en,
    input  logic                run_en,
    input  logic                mode_cont,
    input  logic                fire,
    input  logic [CH_W_P-1:0]   ch_start,
    input  logic [CH_W_P-1:0]   ch_end,
    input  logic                cmp_in,
    output logic                busy,
    output logic                sampling,
    output logic [RES_W_P-1:0]  dac_code,
    output logic [CH_W_P-1:0]   ch_sel,
    output logic                wr_valid,
    output logic                wr_last,
    output logic [CH_W_P-1:0]   wr_ch,
    output logic [RES_W_P-1:0]  wr_data
);
    localparam int CONV_CYC = SAMPLE_CYC_P + RES_W_P + WB_CYC_P;
    localparam int CYC_W    = $clog2(CONV_CYC);
    localparam logic [CYC_W-1:0]  DEC_FIRST = CYC_W'(SAMPLE_CYC_P);
    localparam logic [CYC_W-1:0]  DEC_LAST  = CYC_W'(SAMPLE_CYC_P + RES_W_P - 1);
    localparam logic [CYC_W-1:0]  WB_LAST   = CYC_W'(CONV_CYC - 1);
    localparam logic [CH_W_P-1:0] MAX_CH    = CH_W_P'(NUM_CH_P - 1);

    logic                busy_q;
    logic [CYC_W-1:0]    cyc_q;
    logic [CH_W_P-1:0]   ch_q;
    logic [RES_W_P-1:0]  res_q;
    logic [CH_W_P-1:0]   start_eff, end_eff;
    logic                in_dec, last_ch;
    logic [CYC_W-1:0]    dec_off;
    logic [RES_W_P-1:0]  trial;

    // Clamp the range bounds to the highest existing channel.
    assign start_eff = (ch_start > MAX_CH) ? MAX_CH : ch_start;
    assign end_eff   = (ch_end   > MAX_CH) ? MAX_CH : ch_end;
    assign last_ch   = (ch_q >= end_eff);

    // Trial bit for the current decision tick, MSB first.
    assign in_dec  = busy_q && (cyc_q >= DEC_FIRST) && (cyc_q <= DEC_LAST);
    assign dec_off = DEC_LAST - cyc_q;
    assign trial   = in_dec ? (RES_W_P'(1) << dec_off) : '0;

    // Sequencer state: idle/start, tick counting, bit decisions, channel stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            ch_q   <= '0;
            res_q  <= '0;
        end else if (!busy_q) begin
            if (fire && run_en) begin
                busy_q <= 1'b1;
                cyc_q  <= '0;
                ch_q   <= start_eff;
                res_q  <= '0;
            end
        end else if (conv_en) begin
            if (in_dec) begin
                res_q <= cmp_in ? (res_q | trial) : res_q;
                cyc_q <= cyc_q + 1'b1;
            end else if (cyc_q == WB_LAST) begin
                cyc_q <= '0;
                res_q <= '0;
                if (!last_ch) begin
                    ch_q <= ch_q + 1'b1;
                end else if (mode_cont && run_en) begin
                    ch_q <= start_eff;
                end else begin
                    busy_q <= 1'b0;
                end
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // Outputs to the analog side and the result store.
    assign busy     = busy_q;
    assign sampling = busy_q && (cyc_q < DEC_FIRST);
    assign dac_code = res_q | trial;
    assign ch_sel   = ch_q;
    assign wr_valid = busy_q && conv_en && (cyc_q == WB_LAST);
    assign wr_last  = last_ch;
    assign wr_ch    = ch_q;
    assign wr_data  = res_q;

    // R4: without a tick, the tick counter, channel and partial result hold.
    assert_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !conv_en) |=> ($stable(cyc_q) && $stable(ch_q) && $stable(res_q)));

    // R6: the active channel never leaves the existing set.
    assert_ch_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (ch_q <= MAX_CH));

    // R3: a start pulse during a pass neither ends it nor moves the channel.
    assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && fire && (cyc_q != WB_LAST)) |=> (busy_q && (ch_q == $past(ch_q))));
endmodule

// File: rtl/adc_scan_store.sv
// Module: result storage and interrupt flags. Holds one buffer per channel,
// the shared latest-result register, the window comparator and the two
// sticky write-1-clear flags, where a set beats a simultaneous clear.
// Assumes: wr_ch is below NUM_CH whenever wr_valid is high.
module adc_scan_store
    import adc_scan_pkg::*;
#(
    parameter int RES_W_P  = RES_W,
    parameter int NUM_CH_P = NUM_CH,
    parameter int CH_W_P   = CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic                wr_last,
    input  logic [CH_W_P-1:0]   wr_ch,
    input  logic [RES_W_P-1:0]  wr_data,
    input  logic                win_en,
    input  logic [RES_W_P-1:0]  upper_lim,
    input  logic [RES_W_P-1:0]  lower_lim,
    input  logic                done_clr,
    input  logic                oor_clr,
    input  logic [CH_W_P-1:0]   rd_ch,
    output logic [RES_W_P-1:0]  rd_data,
    output logic [RES_W_P-1:0]  data_out,
    output logic                done_flag,
    output logic                oor_flag
);
    logic [RES_W_P-1:0] buf_q [NUM_CH_P];
    logic [RES_W_P-1:0] data_q;
    logic               done_q, oor_q, oor_hit;

    // One result buffer per channel.
    for (genvar g = 0; g < NUM_CH_P; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)
                buf_q[g] <= '0;
            else if (wr_valid && (wr_ch == CH_W_P'(g)))
                buf_q[g] <= wr_data;
        end
    end

    // Buffer read port; an index without a channel reads zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH_P; i++)
            if (rd_ch == CH_W_P'(i)) rd_data = buf_q[i];
    end

    // Window compare, strict on both bounds.
    assign oor_hit = win_en && ((wr_data > upper_lim) || (wr_data < lower_lim));

    // Shared result register and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            done_q <= 1'b0;
            oor_q  <= 1'b0;
        end else begin
            if (wr_valid) data_q <= wr_data;
            done_q <= (done_q & ~done_clr) | (wr_valid & wr_last);
            oor_q  <= (oor_q & ~oor_clr) | (wr_valid & oor_hit);
        end
    end

    assign data_out  = data_q;
    assign done_flag = done_q;
    assign oor_flag  = oor_q;

    // R10: writing the last channel always leaves the completion flag set.
    assert_done_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_last) |=> done_q);

    // R12: with the window check off, a clear flag stays clear.
    assert_win_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_en && !oor_q) |=> !oor_q);

    // R7: the shared register only changes on a write.
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(data_q));
endmodule

// File: rtl/adc_scan_ctrl.sv
// Module: top of the SAR ADC scan sequencer. Joins trigger selection, the
// SAR pass engine and the result store.
// Assumes: comparator, DAC, multiplexer and prescaler live outside.
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_en,
    input  logic         run_en,
    input  logic         mode_cont,
    input  logic [1:0]   trig_sel,
    input  logic         ext_trig_n,
    input  logic         tmr_match,
    input  logic         sw_start,
    input  logic [2:0]   ch_start,
    input  logic [2:0]   ch_end,
    input  logic         win_en,
    input  logic [9:0]   upper_lim,
    input  logic [9:0]   lower_lim,
    input  logic         cmp_in,
    input  logic         done_clr,
    input  logic         oor_clr,
    input  logic [2:0]   buf_rd_ch,
    output logic [9:0]   dac_code,
    output logic [2:0]   ch_sel,
    output logic         sampling,
    output logic         busy,
    output logic [9:0]   data_out,
    output logic [9:0]   buf_rd_data,
    output logic         done_flag,
    output logic         oor_flag
);
    logic             fire;
    logic             wr_valid, wr_last;
    logic [CH_W-1:0]  wr_ch;
    logic [RES_W-1:0] wr_data;

    adc_scan_trig #(.SYNC_STAGES(2)) u_trig (
        .clk(clk), .rst_n(rst_n), .ext_trig_n(ext_trig_n),
        .tmr_match(tmr_match), .sw_start(sw_start),
        .trig_sel(trig_sel), .fire(fire)
    );

    adc_scan_sar u_sar (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .run_en(run_en),
        .mode_cont(mode_cont), .fire(fire), .ch_start(ch_start),
        .ch_end(ch_end), .cmp_in(cmp_in), .busy(busy), .sampling(sampling),
        .dac_code(dac_code), .ch_sel(ch_sel), .wr_valid(wr_valid),
        .wr_last(wr_last), .wr_ch(wr_ch), .wr_data(wr_data)
    );

    adc_scan_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
        .wr_ch(wr_ch), .wr_data(wr_data), .win_en(win_en),
        .upper_lim(upper_lim), .lower_lim(lower_lim), .done_clr(done_clr),
        .oor_clr(oor_clr), .rd_ch(buf_rd_ch), .rd_data(buf_rd_data),
        .data_out(data_out), .done_flag(done_flag), .oor_flag(oor_flag)
    );
endmodule

// File: tb/adc_scan_ctrl_tb.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_en = 1'b1, slow_ce = 1'b0;
    logic run_en = 1'b1, mode_cont = 1'b0;
    logic [1:0] trig_sel = 2'd2;
    logic ext_trig_n = 1'b1, tmr_match = 1'b0, sw_start = 1'b0;
    logic [2:0] ch_start = 3'd0, ch_end = 3'd0, buf_rd_ch = 3'd0;
    logic win_en = 1'b0;
    logic [9:0] upper_lim = 10'd1023, lower_lim = 10'd0;
    logic cmp_in, done_clr = 1'b0, oor_clr = 1'b0;
    logic [9:0] dac_code, data_out, buf_rd_data;
    logic [2:0] ch_sel;
    logic sampling, busy, done_flag, oor_flag;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [9:0] vin [5];
    logic [9:0] exp_buf [5];
    localparam logic [9:0] BASE [5] = '{10'd0, 10'd1023, 10'd341, 10'd682, 10'd512};

    // Vector: start(3) end(3) src(2) win(1) upper(10) lower(10)
    localparam int NVEC = 6;
    localparam logic [28:0] VEC [NVEC] = '{
        {3'd0, 3'd4, 2'd2, 1'b0, 10'd1023, 10'd0},   // full scan, window off
        {3'd2, 3'd2, 2'd1, 1'b1, 10'd341,  10'd341}, // result equal to both bounds
        {3'd3, 3'd4, 2'd0, 1'b1, 10'd681,  10'd0},   // 682 above upper
        {3'd1, 3'd1, 2'd2, 1'b1, 10'd1023, 10'd0},   // 1023 equal upper
        {3'd6, 3'd7, 2'd2, 1'b1, 10'd1023, 10'd513}, // clamp to ch4, 512 below lower
        {3'd3, 3'd1, 2'd2, 1'b1, 10'd1023, 10'd683}  // start above end: only ch3
    };

    adc_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .run_en(run_en),
        .mode_cont(mode_cont), .trig_sel(trig_sel), .ext_trig_n(ext_trig_n),
        .tmr_match(tmr_match), .sw_start(sw_start), .ch_start(ch_start),
        .ch_end(ch_end), .win_en(win_en), .upper_lim(upper_lim),
        .lower_lim(lower_lim), .cmp_in(cmp_in), .done_clr(done_clr),
        .oor_clr(oor_clr), .buf_rd_ch(buf_rd_ch), .dac_code(dac_code),
        .ch_sel(ch_sel), .sampling(sampling), .busy(busy), .data_out(data_out),
        .buf_rd_data(buf_rd_data), .done_flag(done_flag), .oor_flag(oor_flag)
    );

    always #2.5 clk = ~clk;

    // Ideal comparator model.
    always_comb begin
        cmp_in = 1'b0;
        for (int i = 0; i < 5; i++)
            if (ch_sel == 3'(i)) cmp_in = (vin[i] >= dac_code);
    end

    // Conversion tick: every cycle, or every other cycle when slow_ce is set.
    always @(negedge clk) conv_en <= slow_ce ? ~conv_en : 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd_buf(input int c, output logic [9:0] v);
        buf_rd_ch = 3'(c);
        #0.5;
        v = buf_rd_data;
    endtask

    task automatic fire_src(input logic [1:0] s);
        @(negedge clk);
        trig_sel = s;
        case (s)
            2'd0: ext_trig_n = 1'b0;
            2'd1: tmr_match = 1'b1;
            default: sw_start = 1'b1;
        endcase
        @(negedge clk);
        tmr_match = 1'b0;
        sw_start = 1'b0;
        repeat (3) @(negedge clk);
        ext_trig_n = 1'b1;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done_flag && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk);
        done_clr = 1'b1;
        oor_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        oor_clr = 1'b0;
    endtask

    task automatic idle_watch(input int cyc, input string req);
        int hits = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (busy) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] v;
        int n, smp;
        for (int i = 0; i < 5; i++) begin
            vin[i] = BASE[i];
            exp_buf[i] = 10'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0 && sampling == 1'b0, "R1 busy/sampling", int'(busy), 0);
        chk(done_flag == 1'b0 && oor_flag == 1'b0, "R1 flags", int'(done_flag), 0);
        chk(dac_code == 10'd0 && data_out == 10'd0, "R1 codes", int'(data_out), 0);
        for (int c = 0; c < 5; c++) begin
            rd_buf(c, v);
            chk(v == 10'd0, "R1 buffer", int'(v), 0);
        end

        // Vector table: R2 R5 R6 R7 R8 R11 R12
        for (int k = 0; k < NVEC; k++) begin
            int s, e, last;
            bit exp_oor;
            logic [28:0] vv;
            vv = VEC[k];
            slow_ce = 1'(k % 2);
            ch_start = vv[28:26];
            ch_end = vv[25:23];
            win_en = vv[20];
            upper_lim = vv[19:10];
            lower_lim = vv[9:0];
            s = (int'(vv[28:26]) > 4) ? 4 : int'(vv[28:26]);
            e = (int'(vv[25:23]) > 4) ? 4 : int'(vv[25:23]);
            last = (s > e) ? s : e;
            exp_oor = 1'b0;
            for (int c = 0; c < 5; c++) begin
                if (c >= s && c <= last) begin
                    vin[c] = BASE[c];
                    if (vv[20] && (vin[c] > vv[19:10] || vin[c] < vv[9:0])) exp_oor = 1'b1;
                end else begin
                    vin[c] = ~exp_buf[c];
                end
            end
            clear_flags();
            fire_src(vv[22:21]);
            wait_done(n);
            repeat (2) @(negedge clk);
            chk(done_flag == 1'b1, "R2 R10 pass completed", int'(done_flag), 1);
            chk(busy == 1'b0, "R8 idle after pass", int'(busy), 0);
            chk(data_out == vin[last], "R7 data register", int'(data_out), int'(vin[last]));
            chk(oor_flag == exp_oor, "R11 R12 window", int'(oor_flag), int'(exp_oor));
            for (int c = 0; c < 5; c++) begin
                if (c >= s && c <= last) exp_buf[c] = vin[c];
                rd_buf(c, v);
                chk(v == exp_buf[c], "R5 R6 R7 buffer", int'(v), int'(exp_buf[c]));
            end
        end
        slow_ce = 1'b0;
        repeat (2) @(negedge clk);

        // R4 R10 R11: tick budget, plus set/clear collision on the write-back edge
        ch_start = 3'd2; ch_end = 3'd2; win_en = 1'b1;
        upper_lim = 10'd1023; lower_lim = 10'd400; vin[2] = 10'd341;
        trig_sel = 2'd2;
        clear_flags();
        sw_start = 1'b1;
        n = 0; smp = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            sw_start = 1'b0;
            if (sampling) smp++;
            if (n == 20) begin
                done_clr = 1'b1;
                oor_clr = 1'b1;
            end
        end while (!done_flag && n < 100);
        done_clr = 1'b0;
        oor_clr = 1'b0;
        chk(n == 21, "R4 edges to completion", n, 21);
        chk(smp == 8, "R4 sampling ticks", smp, 8);
        @(negedge clk);
        chk(done_flag == 1'b1, "R10 set beats clear", int'(done_flag), 1);
        chk(oor_flag == 1'b1, "R11 set beats clear", int'(oor_flag), 1);
        clear_flags();
        chk(done_flag == 1'b0, "R10 write-1 clear", int'(done_flag), 0);
        chk(oor_flag == 1'b0, "R11 write-1 clear", int'(oor_flag), 0);

        // R3: retrigger during a pass is ignored
        ch_start = 3'd0; ch_end = 3'd0; win_en = 1'b0;
        fire_src(2'd2);
        fire_src(2'd2);
        wait_done(n);
        idle_watch(30, "R3 no second pass");

        // R2: unselected sources, no-source code, and run_en low
        clear_flags();
        trig_sel = 2'd2;
        @(negedge clk); tmr_match = 1'b1; ext_trig_n = 1'b0;
        @(negedge clk); tmr_match = 1'b0;
        idle_watch(6, "R2 unselected sources");
        ext_trig_n = 1'b1;
        @(negedge clk);
        trig_sel = 2'd3; sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        idle_watch(6, "R2 no-source code");
        trig_sel = 2'd2; run_en = 1'b0; sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        idle_watch(6, "R2 run_en low");
        run_en = 1'b1;

        // R9: continuous mode repeats without a trigger, stops after run_en clears
        mode_cont = 1'b1; ch_start = 3'd0; ch_end = 3'd1;
        vin[0] = 10'd100; vin[1] = 10'd200;
        clear_flags();
        fire_src(2'd2);
        wait_done(n);
        vin[0] = 10'd777;
        clear_flags();
        wait_done(n);
        rd_buf(0, v);
        chk(v == 10'd777, "R9 repeated pass", int'(v), 777);
        chk(busy == 1'b1, "R9 still running", int'(busy), 1);
        run_en = 1'b0;
        n = 0;
        while (busy && n < 500) begin @(negedge clk); n++; end
        clear_flags();
        idle_watch(60, "R9 stopped");
        chk(done_flag == 1'b0, "R9 no pass after stop", int'(done_flag), 0);
        mode_cont = 1'b0; run_en = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule